// File: doc/BRIEF.md
# Modem Line Status Register

This block is the host-visible status register for the four incoming modem handshake lines of a UART-style serial port. The lines are carrier detect, ring, data-set-ready and clear-to-send. Each line arrives as an active-low pin. The block brings the pins into the local clock domain and turns them into positive-logic status levels. It presents those levels in the upper nibble of an 8-bit read word. The lower nibble holds sticky change flags. The flags tell software what moved since it last looked.

A loopback control replaces the pin levels with four of the port's own control outputs, so firmware can test the path without a cable. Such a swap counts as a change like any other. While any change flag is set, a modem-status interrupt request is asserted. A read strobe decoded at the register's address clears the flags. A change that lands in the same cycle as that read is kept for the next read, so no event is lost.

Top module: `mdm_stat_reg`

## Requirements
- R1: `rdata_o[7:4]` shows the current levels of carrier detect (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). Each level is the inverse of its pin in `pin_n_i` (bit 3 carrier, bit 2 ring, bit 1 data-set-ready, bit 0 clear-to-send), delayed by `SYNC_STAGES` clock edges.
- R2: After reset, with all pins high and loopback off, `rdata_o` is 8'h00 and `msi_o` is 0.
- R3: Bits 3, 1 and 0 of `rdata_o` (carrier, data-set-ready, clear-to-send deltas) set one clock edge after the matching level bit changes in either direction. They then stay set until cleared.
- R4: Bit 2 of `rdata_o` sets one edge after the ring level goes from 1 to 0. A 0-to-1 ring transition leaves it unchanged.
- R5: A clock edge with `rd_i` high and `addr_i` equal to `REG_ADDR` (6) clears bits 3..0. A read strobe at any other address leaves them unchanged.
- R6: `msi_o` is 1 exactly when any of `rdata_o[3:0]` is 1.
- R7: With `loop_en_i` high, the levels come from `ctl_i` and the pins are ignored. The mapping is carrier from `ctl_i[3]`, ring from `ctl_i[2]`, data-set-ready from `ctl_i[0]` and clear-to-send from `ctl_i[1]`. The new levels appear in the same cycle.
- R8: When a change and a clearing read happen at the same edge, the read returns the flags as they were before that edge, and the new change's flag is set after the edge.
- R9: Turning loopback on or off sets the delta flag of every level bit that toggles because of the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_n_i | input | 4 | Active-low modem line pins {carrier, ring, dsr, cts} |
| loop_en_i | input | 1 | Loopback enable |
| ctl_i | input | 4 | Control outputs {out2, out1, rts, dtr} used in loopback |
| rd_i | input | 1 | One-cycle host read strobe |
| addr_i | input | ADDR_W (3) | Host register address |
| rdata_o | output | 8 | Status word: levels in [7:4], change flags in [3:0] |
| msi_o | output | 1 | Modem status interrupt request |

## Verification
The bench uses the default parameters: a two-stage synchronizer, a 3-bit address and the register at address 6. It can therefore place a host read exactly on the edge where a synchronized pin change raises its flag. It also drives decoys at the neighbouring address 5. A behavioural model keeps a queue of past pin values, one entry per synchronizer stage. The model predicts the levels and flags at every edge through directed ring rise/fall, loopback entry/exit and same-edge read cases. A long random phase follows.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
  localparam int LINE_N = 4;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  // control outputs: [3]=out2 [2]=out1 [1]=rts [0]=dtr
  function automatic mdm_lines_t loop_map(input logic [LINE_N-1:0] ctl);
    mdm_lines_t l;
    l.dcd = ctl[3];
    l.ri  = ctl[2];
    l.dsr = ctl[0];
    l.cts = ctl[1];
    return l;
  endfunction

  // only ring flags on a falling level
  localparam logic [LINE_N-1:0] FALL_ONLY_MASK = 4'b0100;
endpackage

// File: rtl/mdm_stat_sync.sv
module mdm_stat_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= RST_VAL;
        else         pipe_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mdm_stat_src_mux.sv
module mdm_stat_src_mux
  import mdm_stat_pkg::*;
(
  input  logic [LINE_N-1:0] pin_sync_n_i,
  input  logic              loop_en_i,
  input  logic [LINE_N-1:0] ctl_i,
  output mdm_lines_t        lines_o
);
  mdm_lines_t pin_lines;

  assign pin_lines = mdm_lines_t'(~pin_sync_n_i);
  assign lines_o   = loop_en_i ? loop_map(ctl_i) : pin_lines;
endmodule

// File: rtl/mdm_stat_delta.sv
module mdm_stat_delta #(
  parameter int               WIDTH     = 4,
  parameter logic [WIDTH-1:0] FALL_ONLY = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] state_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] prev_q, flag_q, hit;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    if (FALL_ONLY[g]) begin : g_fall
      assign hit[g] = prev_q[g] & ~state_i[g];
    end else begin : g_any
      assign hit[g] = prev_q[g] ^ state_i[g];
    end
  end

  // a hit on the clearing edge survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= state_i;
      flag_q <= (clr_i ? '0 : flag_q) | hit;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
  import mdm_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int REG_ADDR    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_N-1:0] pin_n_i,
  input  logic              loop_en_i,
  input  logic [LINE_N-1:0] ctl_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        rdata_o,
  output logic              msi_o
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

  logic [LINE_N-1:0] pin_sync_n;
  mdm_lines_t        lines;
  logic [LINE_N-1:0] flags;
  logic              rd_clr;

  mdm_stat_sync #(
    .WIDTH  (LINE_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL({LINE_N{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n_i),
    .q_o   (pin_sync_n)
  );

  mdm_stat_src_mux u_mux (
    .pin_sync_n_i(pin_sync_n),
    .loop_en_i   (loop_en_i),
    .ctl_i       (ctl_i),
    .lines_o     (lines)
  );

  assign rd_clr = rd_i && (addr_i == SEL);

  mdm_stat_delta #(
    .WIDTH    (LINE_N),
    .FALL_ONLY(FALL_ONLY_MASK)
  ) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(lines),
    .clr_i  (rd_clr),
    .flag_o (flags)
  );

  assign rdata_o = {lines, flags};
  assign msi_o   = |flags;
endmodule

// File: rtl/mdm_stat_reg_chk.sv
module mdm_stat_reg_chk #(
  parameter int ADDR_W   = 3,
  parameter int REG_ADDR = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loop_en_i,
  input logic [3:0]        ctl_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              msi_o
);
  logic armed_q;
  logic clr;

  assign clr = rd_i && (addr_i == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o == (rdata_o[3:0] != 4'h0)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |=> ((rdata_o[3:0] & $past(rdata_o[3:0])) == $past(rdata_o[3:0]))); // R3

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && clr && $stable(rdata_o[7:4]) |=> rdata_o[3:0] == 4'h0); // R5

  AST_DCD_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && (rdata_o[7] != $past(rdata_o[7])) |=> rdata_o[3]); // R3

  AST_RING_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $fell(rdata_o[6]) |=> rdata_o[2]); // R4

  AST_RING_RISE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !rdata_o[2] && $rose(rdata_o[6]) |=> !rdata_o[2]); // R4

  AST_LOOP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |-> rdata_o[7:4] == {ctl_i[3], ctl_i[2], ctl_i[0], ctl_i[1]}); // R7
endmodule

bind mdm_stat_reg mdm_stat_reg_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .loop_en_i(loop_en_i),
  .ctl_i    (ctl_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .msi_o    (msi_o)
);

// File: tb/mdm_stat_reg_tb_top.sv
module mdm_stat_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin_n_i = 4'hF;
  logic       loop_en_i = 1'b0;
  logic [3:0] ctl_i = 4'h0;
  logic       rd_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] rdata_o;
  logic       msi_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_stat_reg #(.SYNC_STAGES(SYNC), .ADDR_W(3), .REG_ADDR(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pin_n_i(pin_n_i), .loop_en_i(loop_en_i),
    .ctl_i(ctl_i), .rd_i(rd_i), .addr_i(addr_i), .rdata_o(rdata_o), .msi_o(msi_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [3:0] hist[$];
  logic [3:0] m_prev, m_flags;

  function automatic logic [3:0] m_levels();
    logic [3:0] p;
    if (loop_en_i) return {ctl_i[3], ctl_i[2], ctl_i[0], ctl_i[1]};
    p = hist[SYNC-1];
    return ~p;
  endfunction

  task automatic m_reset();
    hist.delete();
    for (int i = 0; i < SYNC; i++) hist.push_back(4'hF);
    m_prev = 4'h0;
    m_flags = 4'h0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reset();
    end else begin
      logic [3:0] lv, ev;
      lv = m_levels();
      chk("R1 levels", int'(rdata_o[7:4]), int'(lv));
      chk("R3 deltas", int'({rdata_o[3], rdata_o[1:0]}), int'({m_flags[3], m_flags[1:0]}));
      chk("R4 ring flag", int'(rdata_o[2]), int'(m_flags[2]));
      chk("R6 irq", int'(msi_o), int'(m_flags != 0));
      ev = lv ^ m_prev;
      ev[2] = m_prev[2] & ~lv[2];
      if (rd_i && addr_i == 3'd6) m_flags = 4'h0;
      m_flags |= ev;
      m_prev = lv;
      hist.push_front(pin_n_i);
      void'(hist.pop_back());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_read();
    rd_i = 1'b1; addr_i = 3'd6;
    cyc(1);
    rd_i = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R2 reset word", int'(rdata_o), 8'h00);
    chk("R2 reset irq", int'(msi_o), 0);

    pin_n_i[3] = 1'b0;
    cyc(3);
    chk("R3 carrier delta", int'(rdata_o), 8'h88);
    rd_i = 1'b1; addr_i = 3'd5;
    cyc(1);
    rd_i = 1'b0;
    chk("R5 other address keeps flag", int'(rdata_o), 8'h88);
    clr_read();
    chk("R5 cleared", int'(rdata_o), 8'h80);
    chk("R5 irq low", int'(msi_o), 0);

    pin_n_i[2] = 1'b0;
    cyc(3);
    chk("R4 ring rise no flag", int'(rdata_o), 8'hC0);
    pin_n_i[2] = 1'b1;
    cyc(3);
    chk("R4 ring fall flag", int'(rdata_o), 8'h84);
    clr_read();

    pin_n_i[0] = 1'b0;
    cyc(2);
    rd_i = 1'b1; addr_i = 3'd6;
    chk("R8 old flags returned", int'(rdata_o), 8'h90);
    cyc(1);
    rd_i = 1'b0;
    chk("R8 new flag kept", int'(rdata_o), 8'h91);
    clr_read();
    chk("R8 later clear", int'(rdata_o), 8'h90);

    loop_en_i = 1'b1; ctl_i = 4'b0001;
    cyc(1);
    chk("R9 loop entry deltas", int'(rdata_o), 8'h2B);
    clr_read();
    pin_n_i = 4'h0;
    cyc(3);
    chk("R7 pins ignored", int'(rdata_o), 8'h20);
    ctl_i = 4'b1110;
    cyc(1);
    chk("R7 control map", int'(rdata_o), 8'hDB);
    clr_read();
    loop_en_i = 1'b0;
    cyc(1);
    chk("R9 loop exit delta", int'(rdata_o), 8'hF2);
    clr_read();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) pin_n_i = 4'($urandom);
      if ($urandom_range(0, 15) == 0) loop_en_i = ~loop_en_i;
      if ($urandom_range(0, 5) == 0) ctl_i = 4'($urandom);
      rd_i = ($urandom_range(0, 4) == 0);
      addr_i = ($urandom_range(0, 1) == 0) ? 3'd6 : 3'($urandom);
      cyc(1);
    end
    rd_i = 1'b0;
    cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule